// File: doc/BRIEF.md
# Deferred-Accumulate Multiply-Accumulate Unit

This block holds two 64-bit registers: a running accumulator and a product register. The product register is split into an upper half (Hi) and a lower half (Lo). When a multiply-accumulate strobe arrives, the unit does two things in one clock:

- it folds the product left in Hi:Lo by the previous operation into the accumulator;
- it replaces Hi:Lo with the signed product of the two 32-bit operands on its inputs.

The accumulator therefore always trails the multiplier by one operation. A filter loop issues one strobe per tap on consecutive cycles and never stalls.

To collect the last product, software issues a drain strobe. It adds Hi:Lo into the accumulator and empties Hi:Lo. A clear strobe zeroes both registers before a new loop starts. Both 64-bit values are always visible on dedicated outputs. A 32-bit read port, steered by a select input, returns any one half of either register.

Top module: `dmac_unit`

## Requirements
- R1: A synchronous active-high reset sets the accumulator and Hi:Lo to zero at the next rising edge, regardless of the strobes.
- R2: On a multiply-accumulate strobe, Hi:Lo takes the signed two's-complement 64-bit product of the operands at the next edge, with Hi in bits 63:32 and Lo in bits 31:0.
- R3: On a multiply-accumulate strobe, the accumulator takes its old value plus the old Hi:Lo at the same edge, not the new product.
- R4: The accumulator addition wraps modulo 2^64 and does not saturate.
- R5: A clear strobe zeroes both registers in one cycle, and it takes priority over the drain and multiply-accumulate strobes.
- R6: A drain strobe adds the old Hi:Lo into the accumulator and zeroes Hi:Lo. If a multiply-accumulate strobe arrives in the same cycle, the drain wins and the operands are ignored.
- R7: With no strobe asserted, both registers hold their values.
- R8: Multiply-accumulate strobes on consecutive cycles are each accepted, with no stall cycle.
- R9: The read port is combinational. A select of 0 returns Lo, 1 returns Hi, 2 returns the accumulator bits 31:0, and 3 returns the accumulator bits 63:32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mac_go | input | 1 | Multiply-accumulate strobe |
| drain_go | input | 1 | Fold the pending product into the accumulator and empty Hi:Lo |
| clr_go | input | 1 | Zero both registers |
| a_in | input | 32 | First signed operand |
| b_in | input | 32 | Second signed operand |
| rd_sel | input | 2 | Read half select (0 Lo, 1 Hi, 2 accumulator low, 3 accumulator high) |
| rd_data | output | 32 | Selected 32-bit half |
| acc_out | output | 64 | Accumulator value |
| prod_out | output | 64 | Hi:Lo value |

## Verification
The bench checks that the accumulator lags by exactly one step. A design that added its own fresh product would show the accumulator one tap ahead right after the first strobe.

Signed operands at the extremes, such as the most negative value squared and the largest positive value times the most negative value, expose a multiplier that zero-extends its inputs. Repeated 2^62 products push the accumulator past 2^64 and catch any saturation or carry loss.

Strobe collisions (clear with drain, drain with multiply-accumulate) and reset arriving during active strobes reveal a wrong priority order: such a design would leave a stale product or an un-zeroed accumulator.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

    // Resolved operation for one cycle
    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_MAC   = 2'd1,
        OP_DRAIN = 2'd2,
        OP_CLEAR = 2'd3
    } dmac_op_e;

    // Read port half select
    typedef enum logic [1:0] {
        SEL_PROD_LO = 2'd0,
        SEL_PROD_HI = 2'd1,
        SEL_ACC_LO  = 2'd2,
        SEL_ACC_HI  = 2'd3
    } dmac_sel_e;

    // Register update controls
    typedef struct packed {
        logic acc_en;
        logic acc_zero;
        logic prod_en;
        logic prod_zero;
    } dmac_ctl_t;

    // Priority: clear, then drain, then multiply-accumulate
    function automatic dmac_op_e pick_op(input logic clr, input logic drn, input logic mac);
        if (clr)      return OP_CLEAR;
        else if (drn) return OP_DRAIN;
        else if (mac) return OP_MAC;
        else          return OP_HOLD;
    endfunction

    function automatic dmac_ctl_t op_to_ctl(input dmac_op_e op);
        dmac_ctl_t c;
        c = '0;
        case (op)
            OP_CLEAR: begin
                c.acc_en    = 1'b1;
                c.acc_zero  = 1'b1;
                c.prod_en   = 1'b1;
                c.prod_zero = 1'b1;
            end
            OP_DRAIN: begin
                c.acc_en    = 1'b1;
                c.prod_en   = 1'b1;
                c.prod_zero = 1'b1;
            end
            OP_MAC: begin
                c.acc_en  = 1'b1;
                c.prod_en = 1'b1;
            end
            default: c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/dmac_ctrl.sv
module dmac_ctrl
    import dmac_pkg::*;
(
    input  logic      clr_go,
    input  logic      drain_go,
    input  logic      mac_go,
    output dmac_op_e  op,
    output dmac_ctl_t ctl
);
    always_comb begin
        op  = pick_op(clr_go, drain_go, mac_go);
        ctl = op_to_ctl(op);
    end
endmodule

// File: rtl/dmac_mult.sv
module dmac_mult #(
    parameter int OP_W = 32
) (
    input  logic [OP_W-1:0]   a,
    input  logic [OP_W-1:0]   b,
    output logic [2*OP_W-1:0] p
);
    localparam int WIDE_W = 2 * OP_W;

    logic signed [WIDE_W-1:0] a_ext;
    logic signed [WIDE_W-1:0] b_ext;
    logic signed [WIDE_W-1:0] prod_s;

    // Sign-extend both operands, then keep the low WIDE_W bits of the product
    always_comb begin
        a_ext  = {{OP_W{a[OP_W-1]}}, a};
        b_ext  = {{OP_W{b[OP_W-1]}}, b};
        prod_s = a_ext * b_ext;
        p      = prod_s;
    end
endmodule

// File: rtl/dmac_adder.sv
module dmac_adder #(
    parameter int W = 64
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    output logic [W-1:0] s
);
    // Modular sum; the carry out is discarded
    assign s = x + y;
endmodule

// File: rtl/dmac_rdmux.sv
module dmac_rdmux
    import dmac_pkg::*;
#(
    parameter int OP_W = 32
) (
    input  logic [1:0]        sel,
    input  logic [2*OP_W-1:0] acc,
    input  logic [2*OP_W-1:0] prod,
    output logic [OP_W-1:0]   q
);
    always_comb begin
        case (dmac_sel_e'(sel))
            SEL_PROD_LO: q = prod[OP_W-1:0];
            SEL_PROD_HI: q = prod[2*OP_W-1:OP_W];
            SEL_ACC_LO:  q = acc[OP_W-1:0];
            default:     q = acc[2*OP_W-1:OP_W];
        endcase
    end
endmodule

// File: rtl/dmac_unit.sv
module dmac_unit
    import dmac_pkg::*;
#(
    parameter int OP_W = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                mac_go,
    input  logic                drain_go,
    input  logic                clr_go,
    input  logic [OP_W-1:0]     a_in,
    input  logic [OP_W-1:0]     b_in,
    input  logic [1:0]          rd_sel,
    output logic [OP_W-1:0]     rd_data,
    output logic [2*OP_W-1:0]   acc_out,
    output logic [2*OP_W-1:0]   prod_out
);
    localparam int WIDE_W = 2 * OP_W;

    dmac_op_e          op;
    dmac_ctl_t         ctl;
    logic [WIDE_W-1:0] acc_q;
    logic [WIDE_W-1:0] prod_q;
    logic [WIDE_W-1:0] sum;
    logic [WIDE_W-1:0] mul;
    logic [WIDE_W-1:0] acc_d;
    logic [WIDE_W-1:0] prod_d;

    dmac_ctrl u_ctrl (
        .clr_go   (clr_go),
        .drain_go (drain_go),
        .mac_go   (mac_go),
        .op       (op),
        .ctl      (ctl)
    );

    dmac_mult #(.OP_W(OP_W)) u_mult (
        .a (a_in),
        .b (b_in),
        .p (mul)
    );

    // The accumulator always adds the product already held, never the fresh one
    dmac_adder #(.W(WIDE_W)) u_add (
        .x (acc_q),
        .y (prod_q),
        .s (sum)
    );

    always_comb begin
        acc_d  = ctl.acc_zero  ? '0 : sum;
        prod_d = ctl.prod_zero ? '0 : mul;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q  <= '0;
            prod_q <= '0;
        end else begin
            if (ctl.acc_en)  acc_q  <= acc_d;
            if (ctl.prod_en) prod_q <= prod_d;
        end
    end

    dmac_rdmux #(.OP_W(OP_W)) u_rd (
        .sel  (rd_sel),
        .acc  (acc_q),
        .prod (prod_q),
        .q    (rd_data)
    );

    assign acc_out  = acc_q;
    assign prod_out = prod_q;

endmodule

// File: rtl/dmac_unit_chk.sv
module dmac_unit_chk #(
    parameter int OP_W = 32
) (
    input logic                clk,
    input logic                rst,
    input logic                mac_go,
    input logic                drain_go,
    input logic                clr_go,
    input logic [OP_W-1:0]     a_in,
    input logic [OP_W-1:0]     b_in,
    input logic [1:0]          rd_sel,
    input logic [OP_W-1:0]     rd_data,
    input logic [2*OP_W-1:0]   acc_out,
    input logic [2*OP_W-1:0]   prod_out
);
    localparam int WIDE_W = 2 * OP_W;

    logic signed [WIDE_W-1:0] exp_p;
    assign exp_p = WIDE_W'($signed(a_in)) * WIDE_W'($signed(b_in));

    // R1
    reset_zero_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (acc_out == '0 && prod_out == '0));

    // R5
    clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
        clr_go |=> (acc_out == '0 && prod_out == '0));

    // R2
    mac_product_chk: assert property (@(posedge clk) disable iff (rst)
        (mac_go && !clr_go && !drain_go) |=> (prod_out == $past(exp_p)));

    // R3
    deferred_acc_chk: assert property (@(posedge clk) disable iff (rst)
        ((mac_go || drain_go) && !clr_go) |=> (acc_out == $past(acc_out + prod_out)));

    // R6
    drain_empty_chk: assert property (@(posedge clk) disable iff (rst)
        (drain_go && !clr_go) |=> (prod_out == '0));

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!mac_go && !drain_go && !clr_go) |=> ($stable(acc_out) && $stable(prod_out)));

    // R9
    rd_acc_hi_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_sel == 2'd3) |-> (rd_data == acc_out[WIDE_W-1:OP_W]));

    // R9
    rd_prod_lo_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_sel == 2'd0) |-> (rd_data == prod_out[OP_W-1:0]));

endmodule

bind dmac_unit dmac_unit_chk #(.OP_W(OP_W)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .mac_go   (mac_go),
    .drain_go (drain_go),
    .clr_go   (clr_go),
    .a_in     (a_in),
    .b_in     (b_in),
    .rd_sel   (rd_sel),
    .rd_data  (rd_data),
    .acc_out  (acc_out),
    .prod_out (prod_out)
);

// File: tb/dmac_unit_tb_top.sv
module dmac_unit_tb_top;

    logic        clk;
    logic        rst;
    logic        mac_go;
    logic        drain_go;
    logic        clr_go;
    logic [31:0] a_in;
    logic [31:0] b_in;
    logic [1:0]  rd_sel;
    logic [31:0] rd_data;
    logic [63:0] acc_out;
    logic [63:0] prod_out;

    int n_checks;
    int n_fails;

    bit [63:0] m_acc;
    bit [63:0] m_prod;

    dmac_unit dut_i (
        .clk      (clk),
        .rst      (rst),
        .mac_go   (mac_go),
        .drain_go (drain_go),
        .clr_go   (clr_go),
        .a_in     (a_in),
        .b_in     (b_in),
        .rd_sel   (rd_sel),
        .rd_data  (rd_data),
        .acc_out  (acc_out),
        .prod_out (prod_out)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Compare full registers and every read half against the model
    task automatic compare(input string req);
        chk(req, "acc", acc_out, m_acc);
        chk(req, "prod", prod_out, m_prod);
        for (int s = 0; s < 4; s++) begin
            bit [31:0] e;
            rd_sel = 2'(s);
            #1;
            case (s)
                0: e = m_prod[31:0];
                1: e = m_prod[63:32];
                2: e = m_acc[31:0];
                default: e = m_acc[63:32];
            endcase
            chk("R9", "rd_data", {32'd0, rd_data}, {32'd0, e});
        end
    endtask

    // Drive at negedge, update model at posedge, compare at the following negedge
    task automatic step(input bit m, input bit c, input bit d, input int x, input int y, input string req);
        mac_go = m; clr_go = c; drain_go = d;
        a_in = x; b_in = y;
        @(posedge clk);
        if (rst) begin
            m_acc = '0; m_prod = '0;
        end else if (c) begin
            m_acc = '0; m_prod = '0;
        end else if (d) begin
            m_acc = m_acc + m_prod; m_prod = '0;
        end else if (m) begin
            m_acc  = m_acc + m_prod;
            m_prod = longint'(x) * longint'(y);
        end
        @(negedge clk);
        mac_go = 0; clr_go = 0; drain_go = 0;
        compare(req);
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    endtask

    initial begin
        #(20 * 100000);
        n_fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
        $finish;
    end

    initial begin
        n_checks = 0; n_fails = 0;
        m_acc = '0; m_prod = '0;
        rst = 1'b1; mac_go = 1'b1; drain_go = 1'b0; clr_go = 1'b0;
        a_in = 32'd9; b_in = 32'd9; rd_sel = 2'd0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        mac_go = 1'b0;
        compare("R1");

        // R2 and R3: first product, accumulator still zero
        step(1, 0, 0, 3, 4, "R2");
        step(1, 0, 0, -5, 7, "R3");
        // R8: back-to-back strobes with varied signs
        step(1, 0, 0, -1000, -3000, "R8");
        step(1, 0, 0, 32'h7fffffff, 2, "R8");
        step(1, 0, 0, 123456, -654321, "R8");
        // R7: idle holds, operands ignored
        step(0, 0, 0, 77, 88, "R7");
        step(0, 0, 0, -1, -1, "R7");
        // R6: drain beats simultaneous mac
        step(1, 0, 1, 55, 66, "R6");
        step(0, 0, 1, 0, 0, "R6");
        // R5: clear beats drain and mac
        step(1, 0, 0, 11, 13, "R5");
        step(1, 1, 1, 17, 19, "R5");
        // R2: signed extremes
        step(1, 0, 0, 32'h7fffffff, 32'h80000000, "R2");
        step(1, 0, 0, 32'h80000000, 32'h80000000, "R2");
        step(0, 1, 0, 0, 0, "R5");
        // R4: wrap past 2^64 with repeated 2^62
        for (int i = 0; i < 5; i++) step(1, 0, 0, 32'h80000000, 32'h80000000, "R4");
        step(0, 0, 1, 0, 0, "R4");
        step(1, 0, 0, -2, 3, "R3");
        // R1: reset while strobes active
        rst = 1'b1;
        step(1, 0, 1, 5, 5, "R1");
        rst = 1'b0;
        step(1, 0, 0, 6, -6, "R2");

        summary();
        $finish;
    end

endmodule